// File: doc/BRIEF.md
# Xoroshiro128+ Random Word Source

This block produces a stream of 64-bit pseudo-random words using the xoroshiro128+ recurrence. It keeps 128 bits of state split into a low half (`s0`, state bits 63..0) and a high half (`s1`, state bits 127..64). The word offered on the output is the sum of the two halves, truncated to 64 bits.

Words leave through a ready/valid handshake. The state moves to its next value only when a word is taken, so a stalled consumer sees the same word for as long as it waits. A parameter gives the state that is loaded during synchronous reset. At run time a one-cycle `reseed` pulse loads a new 128-bit state from `seed_in`.

Top module: `xoro_rng`

## Requirements
- R1: While `rst` is high at a clock edge, the state is loaded from parameter `SEED` and `out_valid` is low after that edge, whatever `out_ready` is.
- R2: One clock edge after `rst` is released, `out_valid` is high and `out_data` equals `SEED[63:0] + SEED[127:64]` mod 2^64.
- R3: `out_data` is always `s0 + s1` mod 2^64, where `s0` is state bits 63..0 and `s1` is state bits 127..64.
- R4: When a word is taken, the state advances as follows: t = s1 ^ s0, new s0 = rotl(s0,24) ^ t ^ (t << 16), new s1 = rotl(t,37).
- R5: While `out_ready` is low and no reseed or reset occurs, `out_valid` stays high and `out_data` holds its value for any number of cycles.
- R6: With `out_ready` held high, a new word is presented on every cycle and `out_valid` never drops.
- R7: A one-cycle `reseed` pulse loads `seed_in` into the state. On the next cycle `out_valid` is high and `out_data` is taken from the new seed.
- R8: If `rst` and `reseed` are both high at the same edge, reset wins and the state becomes `SEED`.
- R9: If `reseed` and a handshake happen at the same edge, the state becomes `seed_in` and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reseed | input | 1 | Load `seed_in` into the state |
| seed_in | input | 128 | New state: bits 63..0 go to s0, bits 127..64 go to s1 |
| out_ready | input | 1 | Consumer accepts the current word |
| out_valid | output | 1 | A word is on offer |
| out_data | output | 64 | The current word |

## Verification
A reseed pulse and a handshake can land on the same clock edge. The bench raises `reseed` while `out_ready` is high and `out_valid` is set. It then requires that the next word equals the sum of the new seed's halves and not an advanced state. Reset and reseed can also coincide. The bench drives both together and expects that, after reset is released, the first word comes from `SEED`. Both full streams, one from the default seed and one from the runtime seed, are compared word for word against a bench model under pseudo-random stalls.

// File: rtl/xoro_rng.sv
module xoro_rng #(
  parameter logic [127:0] SEED = 128'h0123456789abcdef3141592653589793
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  logic [127:0] seed_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [63:0]  out_data
);

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  logic [63:0] s0, s1, t, s0_nx, s1_nx;
  logic        take;

  assign take     = out_ready & out_valid;
  assign out_data = s0 + s1;
  assign t        = s1 ^ s0;
  assign s0_nx    = rotl(s0, 24) ^ t ^ (t << 16);
  assign s1_nx    = rotl(t, 37);

  always_ff @(posedge clk) begin
    if (rst) begin
      s0        <= SEED[63:0];
      s1        <= SEED[127:64];
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      if (reseed) begin
        s0 <= seed_in[63:0];
        s1 <= seed_in[127:64];
      end else if (take) begin
        s0 <= s0_nx;
        s1 <= s1_nx;
      end
    end
  end

  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> out_data == SEED[63:0] + SEED[127:64]); // R2
  AST_VALID_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (!out_ready && out_valid && !reseed) |=> (out_valid && $stable(out_data))); // R5
  AST_RESEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    reseed |=> out_data == $past(seed_in[63:0]) + $past(seed_in[127:64])); // R7

endmodule

// File: tb/test_xoro_rng.sv
module test_xoro_rng;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] DEF_SEED = 128'h0123456789abcdef3141592653589793;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reseed = 1'b0;
  logic [127:0] seed_in = '0;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [63:0]  out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m0, m1;

  xoro_rng #(.SEED(DEF_SEED)) i_xoro_rng (
    .clk(clk), .rst(rst), .reseed(reseed), .seed_in(seed_in),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  task automatic model_load(input logic [127:0] s);
    m0 = s[63:0];
    m1 = s[127:64];
  endtask

  task automatic model_step();
    logic [63:0] tt;
    tt = m0 ^ m1;
    m0 = rl(m0, 24) ^ tt ^ (tt << 16);
    m1 = rl(tt, 37);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; out_ready = 1'b1;
    tick(); tick();
    chk("R1 valid low in reset", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    tick();
    model_load(DEF_SEED);
    chk("R2 valid after release", {63'd0, out_valid}, 64'd1);
    chk("R2 first word", out_data, DEF_SEED[63:0] + DEF_SEED[127:64]);
    out_ready = 1'b0;
  endtask

  task automatic t_stream(input int words, input string req);
    for (int i = 0; i < words; i++) begin
      logic [63:0] held;
      chk({req, " R3 R4 word"}, out_data, m0 + m1);
      if (i % 7 == 3 || ($urandom % 4) == 0) begin
        held = out_data;
        out_ready = 1'b0;
        for (int k = 0; k < 1 + (i % 3); k++) begin
          tick();
          chk("R5 hold data", out_data, held);
          chk("R5 hold valid", {63'd0, out_valid}, 64'd1);
        end
      end
      out_ready = 1'b1;
      tick();
      model_step();
      chk("R6 valid no gap", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1'b0;
  endtask

  task automatic t_reseed_collide(input logic [127:0] s);
    out_ready = 1'b1; reseed = 1'b1; seed_in = s;
    tick();
    reseed = 1'b0; seed_in = '0; out_ready = 1'b0;
    model_load(s);
    chk("R7 R9 reseed over handshake", out_data, s[63:0] + s[127:64]);
    chk("R7 valid after reseed", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset_vs_reseed();
    rst = 1'b1; reseed = 1'b1; seed_in = 128'hffff0000ffff0000_1234123412341234;
    tick();
    reseed = 1'b0; seed_in = '0;
    chk("R1 valid low", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    tick();
    model_load(DEF_SEED);
    chk("R8 reset beats reseed", out_data, DEF_SEED[63:0] + DEF_SEED[127:64]);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stream(1000, "seed1");
    t_reseed_collide(128'h3141592653589793fedcba9876543210);
    t_stream(1000, "seed2");
    t_reset_vs_reseed();
    t_stream(20, "after reset");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule